// File: doc/BRIEF.md
# Dual-Plane Deflecting Banyan Fabric

This block is a self-routing switch fabric with eight input ports and eight output ports. It is built from two banyan planes side by side, each with log2(ports) routing stages. Each stage steers a cell using one bit of the cell's destination. Links between the planes at every stage let a cell step over to the other plane when the element it would enter next is marked faulty. Because every hop still moves the cell one stage forward, the number of hops stays the same however often the cell changes plane.

One cell enters per cycle. A splitter at the entry gives each cell a choice of planes, and a merge register at each output brings the two planes back together. The fault map is a static bit mask with one bit per element per plane per stage. If a cell meets a stage where the element in both planes is faulty, it is discarded. A drop pulse then carries its destination out, in the same cycle the cell would otherwise have been delivered.

Top module: `dpbf_fabric`

## Requirements
- R1: While reset is held, and after it is released with no input, outVld is all zero and dropVld is low.
- R2: A cell accepted from input s with destination d leaves on output d only, with its data unchanged. On a fault-free fabric this holds for every pair (s, d).
- R3: The delivery or drop pulse for a cell shows up exactly STAGES+2 (5) rising edges after the edge that accepts it, counting the accepting edge as the first.
- R4: The fault mask bit for plane p, stage i and element e is at index (p*STAGES + i)*(PORTS/2) + e. Element e is the cell's current line number with bit i taken out. The line number starts as the source port. After stage i, bit i of the line is replaced by destination bit i.
- R5: A cell enters stage 0 in plane 0. At any stage where the element in its current plane is faulty but the element at the same position in the other plane is healthy, the cell moves to the other plane and is still delivered as in R2.
- R6: If both planes' elements are faulty at a stage the cell must enter, no output is raised for that cell. Instead dropVld pulses for one cycle with dropDest equal to its destination, at the time given in R3.
- R7: Cells accepted in consecutive cycles leave in the order they were accepted.
- R8: When several bits of inVld are set in one cycle, only the lowest-numbered valid input is accepted. The other inputs in that cycle produce neither an output nor a drop.
- R9: At most one bit of outVld is set in any cycle, and outVld is never non-zero while dropVld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 8 | Per-input cell valid |
| inData | input | 128 | Per-input cell data, 16 bits per input, input k at bits [16k+15:16k] |
| inDest | input | 24 | Per-input destination, 3 bits per input, input k at bits [3k+2:3k] |
| faultMask | input | 24 | Static element fault map, bit layout as in R4, 1 = faulty |
| outVld | output | 8 | Per-output cell valid |
| outData | output | 128 | Per-output cell data, same layout as inData |
| dropVld | output | 1 | One-cycle pulse for a discarded cell |
| dropDest | output | 3 | Destination of the discarded cell |

## Verification
Some properties are checked by assertions on every cycle. A live cell leaving a stage must always sit in a healthy element. A change of plane is allowed only when the element in the plane the cell came from was faulty. Outputs are one-hot and never overlap a drop. Every accepted cell produces exactly one result after the fixed latency. Other behaviours can only be shown by the bench scenarios: that the right output port receives the right data, that the mask bit layout matches R4, that cells drop exactly when both planes are blocked, and that lowest-index selection and in-order delivery hold. The bench predicts each result from the mask and compares it under a full source-destination sweep, targeted deflect and drop cases, and random single-fault and multi-fault masks.

// File: rtl/dpbf_pkg.sv
package dpbf_pkg;
  localparam int PORTS  = 8;
  localparam int DATA_W = 16;
  localparam int STAGES = $clog2(PORTS);
  localparam int HALF   = PORTS / 2;
  localparam int PLANES = 2;
  localparam int MASK_W = PLANES * STAGES * HALF;

  typedef logic [STAGES-1:0] port_t;

  // one cell slot in the pipeline
  typedef struct packed {
    logic              vld;
    logic              dead;
    logic              plane;
    port_t             line;
    port_t             dest;
    logic [DATA_W-1:0] data;
  } cell_t;

  // strobes from steering control to the datapath, one bit per stage
  typedef struct packed {
    logic [STAGES-1:0] usePlane;
    logic [STAGES-1:0] kill;
  } steer_t;

  // element position inside a stage: the line number with the stage bit removed
  function automatic int elemOf(input int stage, input port_t line);
    int l;
    l = int'(line);
    return ((l >> (stage + 1)) << stage) | (l & ((1 << stage) - 1));
  endfunction

  function automatic logic isFaulty(input logic [MASK_W-1:0] mask, input logic plane,
                                    input int stage, input port_t line);
    int idx;
    idx = (int'(plane) * STAGES + stage) * HALF + elemOf(stage, line);
    return mask[idx];
  endfunction
endpackage

// File: rtl/dpbf_steer.sv
module dpbf_steer
  import dpbf_pkg::*;
(
  input  logic [MASK_W-1:0] faultMask,
  input  cell_t             stageCells [STAGES],
  output steer_t            steer
);
  // per stage: keep plane if healthy, else deflect, else kill
  always_comb begin
    steer = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (!isFaulty(faultMask, stageCells[i].plane, i, stageCells[i].line)) begin
        steer.usePlane[i] = stageCells[i].plane;
      end else if (!isFaulty(faultMask, !stageCells[i].plane, i, stageCells[i].line)) begin
        steer.usePlane[i] = !stageCells[i].plane;
      end else begin
        steer.usePlane[i] = stageCells[i].plane;
        steer.kill[i]     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpbf_path.sv
module dpbf_path
  import dpbf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PORTS-1:0]          inVld,
  input  logic [PORTS*DATA_W-1:0]   inData,
  input  logic [PORTS*STAGES-1:0]   inDest,
  input  logic [MASK_W-1:0]         faultMask,
  input  steer_t                    steer,
  output cell_t                     stageCells [STAGES],
  output logic [PORTS-1:0]          outVld,
  output logic [PORTS*DATA_W-1:0]   outData,
  output logic                      dropVld,
  output logic [STAGES-1:0]         dropDest
);
  cell_t pipe [STAGES+1];
  port_t selPort;

  // entry pick: lowest-numbered valid input
  always_comb begin
    selPort = '0;
    for (int k = PORTS - 1; k >= 0; k--) begin
      if (inVld[k]) selPort = port_t'(k);
    end
  end

  // 1x2 splitter register: cell starts in plane 0 on its source line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe[0] <= '0;
    end else begin
      pipe[0].vld   <= |inVld;
      pipe[0].dead  <= 1'b0;
      pipe[0].plane <= 1'b0;
      pipe[0].line  <= selPort;
      pipe[0].dest  <= inDest[int'(selPort)*STAGES +: STAGES];
      pipe[0].data  <= inData[int'(selPort)*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    for (int i = 0; i < STAGES; i++) stageCells[i] = pipe[i];
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cell_t hopNext;
      always_comb begin
        hopNext           = pipe[i];
        hopNext.plane     = steer.usePlane[i];
        hopNext.dead      = pipe[i].dead | (pipe[i].vld & steer.kill[i]);
        hopNext.line[i]   = pipe[i].dest[i];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[i+1] <= '0;
        else       pipe[i+1] <= hopNext;
      end

      // R5: a live cell never rests in a faulty element
      p_healthy_hop_r5: assert property (@(posedge clk) disable iff (!rstN)
        (pipe[i+1].vld && !pipe[i+1].dead) |->
          !isFaulty(faultMask, pipe[i+1].plane, i, pipe[i+1].line));

      // R5: plane changes only when the element in the old plane was faulty
      p_deflect_needed_r5: assert property (@(posedge clk) disable iff (!rstN)
        (pipe[i+1].vld && !pipe[i+1].dead && (pipe[i+1].plane != $past(pipe[i].plane))) |->
          $past(isFaulty(faultMask, pipe[i].plane, i, pipe[i].line)));
    end
  endgenerate

  // 2x1 merge register: whichever plane the cell used, drive its output line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld   <= '0;
      outData  <= '0;
      dropVld  <= 1'b0;
      dropDest <= '0;
    end else begin
      outVld   <= '0;
      outData  <= '0;
      dropVld  <= pipe[STAGES].vld & pipe[STAGES].dead;
      dropDest <= pipe[STAGES].dest;
      if (pipe[STAGES].vld && !pipe[STAGES].dead) begin
        outVld[pipe[STAGES].line] <= 1'b1;
        outData[int'(pipe[STAGES].line)*DATA_W +: DATA_W] <= pipe[STAGES].data;
      end
    end
  end

  p_onehot_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outVld));

  p_out_xor_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    !((|outVld) && dropVld));

  p_fixed_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|inVld) |-> ##(STAGES+2) ((|outVld) || dropVld));
endmodule

// File: rtl/dpbf_fabric.sv
module dpbf_fabric
  import dpbf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PORTS-1:0]          inVld,
  input  logic [PORTS*DATA_W-1:0]   inData,
  input  logic [PORTS*STAGES-1:0]   inDest,
  input  logic [MASK_W-1:0]         faultMask,
  output logic [PORTS-1:0]          outVld,
  output logic [PORTS*DATA_W-1:0]   outData,
  output logic                      dropVld,
  output logic [STAGES-1:0]         dropDest
);
  steer_t steer;
  cell_t  stageCells [STAGES];

  dpbf_steer u_steer (
    .faultMask (faultMask),
    .stageCells(stageCells),
    .steer     (steer)
  );

  dpbf_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .inVld     (inVld),
    .inData    (inData),
    .inDest    (inDest),
    .faultMask (faultMask),
    .steer     (steer),
    .stageCells(stageCells),
    .outVld    (outVld),
    .outData   (outData),
    .dropVld   (dropVld),
    .dropDest  (dropDest)
  );
endmodule

// File: tb/sim_dpbf_fabric.sv
module sim_dpbf_fabric;
  import dpbf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PORTS-1:0]        inVld = '0;
  logic [PORTS*DATA_W-1:0] inData = '0;
  logic [PORTS*STAGES-1:0] inDest = '0;
  logic [MASK_W-1:0]       faultMask = '0;
  logic [PORTS-1:0]        outVld;
  logic [PORTS*DATA_W-1:0] outData;
  logic                    dropVld;
  logic [STAGES-1:0]       dropDest;

  typedef struct {
    int                cyc;
    bit                drop;
    int                dest;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;

  exp_t expQ[$];
  int cyc = 0, checks = 0, fails = 0;
  bit running = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpbf_fabric u0 (.clk(clk), .rstN(rstN), .inVld(inVld), .inData(inData), .inDest(inDest),
                  .faultMask(faultMask), .outVld(outVld), .outData(outData),
                  .dropVld(dropVld), .dropDest(dropDest));

  // routing model from R4/R5/R6
  function automatic bit predictDrop(int src, int dest);
    int line = src;
    int pl = 0;
    for (int s = 0; s < STAGES; s++) begin
      int e = ((line >> (s + 1)) << s) | (line & ((1 << s) - 1));
      if (faultMask[(pl*STAGES + s)*HALF + e]) begin
        if (faultMask[((1-pl)*STAGES + s)*HALF + e]) return 1'b1;
        pl = 1 - pl;
      end
      line = (line & ~(1 << s)) | (((dest >> s) & 1) << s);
    end
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic sendCell(int src, int dest, logic [DATA_W-1:0] data, string req);
    exp_t e;
    inVld = '0;
    inVld[src] = 1'b1;
    inDest[src*STAGES +: STAGES] = STAGES'(dest);
    inData[src*DATA_W +: DATA_W] = data;
    e.cyc = cyc + STAGES + 2;   // R3
    e.drop = predictDrop(src, dest);
    e.dest = dest; e.data = data; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    inVld = '0;
  endtask

  task automatic drain();
    repeat (STAGES + 5) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        if (e.drop) begin
          check(dropVld && dropDest == STAGES'(e.dest) && outVld == '0, e.req,
                "drop pulse/dest", {dropVld, dropDest}, {1'b1, STAGES'(e.dest)});
        end else begin
          check(outVld == PORTS'(1 << e.dest) && !dropVld, e.req, "output valid",
                int'({dropVld, outVld}), 1 << e.dest);
          check(outData[e.dest*DATA_W +: DATA_W] == e.data, e.req, "output data",
                int'(outData[e.dest*DATA_W +: DATA_W]), int'(e.data));
        end
      end else begin
        if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
          exp_t e;
          e = expQ.pop_front();
          check(1'b0, e.req, "result missing", 0, e.cyc);
        end
        if ((|outVld) || dropVld)
          check(1'b0, "R8/R9", "unexpected output", int'({dropVld, outVld}), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: idle during and after reset
    repeat (3) @(negedge clk);
    check(outVld == '0 && !dropVld, "R1", "idle in reset", int'({dropVld, outVld}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outVld == '0 && !dropVld, "R1", "idle after reset", int'({dropVld, outVld}), 0);
    running = 1;

    // R2 R3 R7: full sweep, back to back, healthy fabric
    for (int s = 0; s < PORTS; s++)
      for (int d = 0; d < PORTS; d++)
        sendCell(s, d, DATA_W'(16'hA000 + s*16 + d), "R2");
    drain();

    // R7: same pair, consecutive cycles, ordering seen through data
    sendCell(4, 1, 16'h1111, "R7");
    sendCell(4, 1, 16'h2222, "R7");
    sendCell(4, 1, 16'h3333, "R7");
    drain();

    // R8: inputs 2,4,5,7 valid, input k heads for 7-k; only input 2 accepted
    begin
      exp_t e;
      for (int k = 0; k < PORTS; k++) begin
        inDest[k*STAGES +: STAGES] = STAGES'(PORTS - 1 - k);
        inData[k*DATA_W +: DATA_W] = DATA_W'(16'hB000 + k);
      end
      inVld = 8'b1011_0100;
      e.cyc = cyc + STAGES + 2; e.drop = 0; e.dest = 5; e.data = 16'hB002; e.req = "R8";
      expQ.push_back(e);
      @(negedge clk);
      inVld = '0;
      drain();
    end

    // R5: src 0 -> dest 7, plane 0 stage 1 element 1 (bit 5) faulty: deflect
    faultMask = '0; faultMask[5] = 1'b1;
    sendCell(0, 7, 16'hC0DE, "R5");
    // R5: src 3, plane 0 stage 0 element 1 (bit 1) faulty: enters plane 1
    faultMask[1] = 1'b1;
    sendCell(3, 2, 16'hC0DF, "R5");
    drain();
    // R6: same element also faulty in plane 1 (bit 17): drop
    faultMask = '0; faultMask[5] = 1'b1; faultMask[17] = 1'b1;
    sendCell(0, 7, 16'hDEAD, "R6");
    sendCell(0, 6, 16'hBEEF, "R4"); // line 0 at stage 1, element 0 is healthy
    drain();

    // R4 R5: random single faults
    for (int m = 0; m < 16; m++) begin
      faultMask = '0;
      faultMask[$urandom_range(MASK_W-1, 0)] = 1'b1;
      for (int c = 0; c < 10; c++)
        sendCell($urandom_range(PORTS-1, 0), $urandom_range(PORTS-1, 0),
                 DATA_W'($urandom), "R5");
      drain();
    end

    // R4 R6: random multiple faults, drops expected
    for (int m = 0; m < 20; m++) begin
      faultMask = '0;
      repeat (6) faultMask[$urandom_range(MASK_W-1, 0)] = 1'b1;
      for (int c = 0; c < 10; c++)
        sendCell($urandom_range(PORTS-1, 0), $urandom_range(PORTS-1, 0),
                 DATA_W'($urandom), "R6");
      drain();
    end

    running = 0;
    if (expQ.size() != 0) check(1'b0, "R3", "results left over", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule